// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

A single down-counter with a word-indexed register interface and one interrupt line. Software picks a counting mode (free-running, periodic or one-shot), a counter width (16 or 32 bits), a prescale divisor applied to an external tick-enable input, and whether the expiry flag drives the interrupt. The counter takes one step for each prescaled tick while enabled. On expiry it latches a raw interrupt flag and either reloads or halts, depending on the mode.

Two register indices set the reload value. One also reloads the count in the same cycle. The other only stages a new reload value, which takes effect at the next expiry. This lets software change the period without breaking the current interval. Software can read the interrupt flag both before and after the enable mask. Register writes take effect at the next clock edge, and reads are combinational from the index.

Top module: `interval_timer`

## Requirements
- R1: After reset the control register reads 0x20 (interrupt enable only, counter disabled), the current value reads 0x0000FFFF, the load register reads 0, the raw flag is clear and `irq_o` is low.
- R2: Register indices on `addr_i` are: 0 load, 1 current value, 2 control, 3 interrupt clear, 4 raw status (bit 0), 5 masked status (bit 0), 6 background load.
- R3: Control bits: bit 7 enable, bit 6 periodic, bit 5 interrupt enable, bits 3:2 prescale code, bit 1 selects 32-bit width, bit 0 one-shot. The control register reads back the 8 bits written, and bits 31:8 read as zero.
- R4: The prescaler counts `tick_i` pulses only while enable is set. Prescale code 0 or 3 gives one counter step per tick, code 1 gives one step per 16 ticks and code 2 gives one step per 256 ticks. A control write restarts the prescale phase.
- R5: In periodic mode with reload value N ≥ 1, the count goes N, N-1, ..., 1. The Nth step is the expiry: it sets the raw flag and puts N back into the count.
- R6: With periodic and one-shot both clear (free-running), an expiry reloads 0xFFFF in 16-bit mode and 0xFFFFFFFF in 32-bit mode, whatever load value is programmed.
- R7: In one-shot mode the expiry step leaves the count at 0. Further ticks then leave the count unchanged and set no flag, until the count is reloaded.
- R8: A write to index 0 stores the reload value and reloads the count in the same cycle (with the size maximum in free-running mode). A write to index 6 stores the reload value only. Both indices read back the stored reload value.
- R9: An expiry sets the raw flag. Any write to index 3 clears it. If both happen in the same cycle, the expiry wins.
- R10: `irq_o` and the masked status are the raw flag gated by interrupt enable. Both are zero while interrupt enable is clear.
- R11: Writes to index 1 leave the count, the reload value and the control register unchanged.
- R12: In 16-bit mode only bits 15:0 of the count take part. Bits 31:16 of the current value read as zero.
- R13: Indices 3 and 7 read zero. A write to index 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Tick enable feeding the prescaler |
| wr_i | input | 1 | Write strobe, one cycle per write |
| addr_i | input | 3 | Word register index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the register at `addr_i` |
| irq_o | output | 1 | Interrupt, raw flag gated by interrupt enable |

## Verification
The hardest case to reach from the ports is a free-running wrap, because getting there directly means stepping through 65536 or 2^32 counts. The bench first loads a small count in periodic mode, then rewrites only the control register to select free-running. The count is left alone, so expiry arrives within a few ticks and the size-dependent maximum can be seen being reloaded. The periodic length, each prescale code and the one-shot halt are swept over small ranges, and the expected expiry tick is computed arithmetically from the reload value and the divisor.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int DATA_W   = 32;
  localparam int NARROW_W = 16;
  localparam int ADDR_W   = 3;
  localparam int CTRL_W   = 8;

  localparam logic [ADDR_W-1:0] IDX_LOAD  = 3'd0;
  localparam logic [ADDR_W-1:0] IDX_VALUE = 3'd1;
  localparam logic [ADDR_W-1:0] IDX_CTRL  = 3'd2;
  localparam logic [ADDR_W-1:0] IDX_ICLR  = 3'd3;
  localparam logic [ADDR_W-1:0] IDX_RAW   = 3'd4;
  localparam logic [ADDR_W-1:0] IDX_MSK   = 3'd5;
  localparam logic [ADDR_W-1:0] IDX_BGLD  = 3'd6;

  typedef enum logic [1:0] {
    PRE_DIV1   = 2'd0,
    PRE_DIV16  = 2'd1,
    PRE_DIV256 = 2'd2,
    PRE_RSVD   = 2'd3
  } pre_e;

  typedef struct packed {
    logic en;
    logic periodic;
    logic ie;
    logic spare;
    pre_e pre;
    logic size32;
    logic oneshot;
  } ctrl_t;

  localparam logic [CTRL_W-1:0] CTRL_RST = 8'h20;
endpackage

// File: rtl/timer_prescale.sv
module timer_prescale #(
  parameter int PRE_W    = 8,
  parameter int DIV_MID  = 16,
  parameter int DIV_HIGH = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  timer_pkg::pre_e  pre_i,
  input  logic             restart_i,
  output logic             step_o
);
  localparam logic [PRE_W-1:0] LIM_MID  = PRE_W'(DIV_MID - 1);
  localparam logic [PRE_W-1:0] LIM_HIGH = PRE_W'(DIV_HIGH - 1);

  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] lim;
  logic             hit;

  always_comb begin
    unique case (pre_i)
      timer_pkg::PRE_DIV16:  lim = LIM_MID;
      timer_pkg::PRE_DIV256: lim = LIM_HIGH;
      default:               lim = '0;
    endcase
  end

  assign hit    = (phase_q == lim);
  assign step_o = tick_i & en_i & hit & ~restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                phase_q <= '0;
    else if (restart_i)         phase_q <= '0;
    else if (tick_i && en_i)    phase_q <= hit ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              oneshot_i,
  input  logic              periodic_i,
  input  logic              size32_i,
  input  logic [DATA_W-1:0] reload_i,
  input  logic              load_now_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic [DATA_W-1:0] value_o,
  output logic              expire_o
);
  localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [DATA_W-1:0] ONE         = DATA_W'(1);

  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] width_mask;
  logic [DATA_W-1:0] eff;
  logic              freerun;
  logic              halted;
  logic              active;

  assign width_mask = size32_i ? '1 : NARROW_MASK;
  assign eff        = cnt_q & width_mask;
  assign freerun    = ~(oneshot_i | periodic_i);
  assign halted     = oneshot_i & (eff == '0);
  assign active     = step_i & ~halted;
  assign expire_o   = active & ~load_now_i & (eff <= ONE);
  assign value_o    = eff;

  function automatic logic [DATA_W-1:0] pick_reload(input logic fr,
                                                     input logic [DATA_W-1:0] src,
                                                     input logic [DATA_W-1:0] msk);
    return fr ? msk : (src & msk);
  endfunction

  always_comb begin
    cnt_d = cnt_q;
    if (load_now_i)
      cnt_d = pick_reload(freerun, load_data_i, width_mask);
    else if (expire_o)
      cnt_d = oneshot_i ? '0 : pick_reload(freerun, reload_i, width_mask);
    else if (active)
      cnt_d = eff - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '1;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] value_i,
  input  logic          expire_i,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] reload_o,
  output logic          load_now_o,
  output logic          ctrl_wr_o,
  output logic          raw_o,
  output logic [DW-1:0] rdata_o
);
  ctrl_t         ctrl_q;
  logic [DW-1:0] reload_q;
  logic          raw_q;
  logic          iclr_wr;
  logic          bgld_wr;

  assign load_now_o = wr_i & (addr_i == IDX_LOAD);
  assign ctrl_wr_o  = wr_i & (addr_i == IDX_CTRL);
  assign iclr_wr    = wr_i & (addr_i == IDX_ICLR);
  assign bgld_wr    = wr_i & (addr_i == IDX_BGLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= ctrl_t'(CTRL_RST);
      reload_q <= '0;
      raw_q    <= 1'b0;
    end else begin
      if (ctrl_wr_o)               ctrl_q   <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (load_now_o || bgld_wr)   reload_q <= wdata_i;
      if (expire_i)                raw_q    <= 1'b1;
      else if (iclr_wr)            raw_q    <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      IDX_LOAD, IDX_BGLD: rdata_o = reload_q;
      IDX_VALUE:          rdata_o = value_i;
      IDX_CTRL:           rdata_o = DW'(ctrl_q);
      IDX_RAW:            rdata_o = DW'(raw_q);
      IDX_MSK:            rdata_o = DW'(raw_q & ctrl_q.ie);
      default:            rdata_o = '0;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
  assign raw_o    = raw_q;
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int PRE_W    = 8,
  parameter int DIV_MID  = 16,
  parameter int DIV_HIGH = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] reload;
  logic [DATA_W-1:0] value;
  logic              load_now;
  logic              ctrl_wr;
  logic              raw;
  logic              step;
  logic              expire;

  timer_regs #(.DW(DATA_W), .AW(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .value_i    (value),
    .expire_i   (expire),
    .ctrl_o     (ctrl),
    .reload_o   (reload),
    .load_now_o (load_now),
    .ctrl_wr_o  (ctrl_wr),
    .raw_o      (raw),
    .rdata_o    (rdata_o)
  );

  timer_prescale #(.PRE_W(PRE_W), .DIV_MID(DIV_MID), .DIV_HIGH(DIV_HIGH)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .en_i      (ctrl.en),
    .pre_i     (ctrl.pre),
    .restart_i (ctrl_wr),
    .step_o    (step)
  );

  timer_counter #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .oneshot_i   (ctrl.oneshot),
    .periodic_i  (ctrl.periodic),
    .size32_i    (ctrl.size32),
    .reload_i    (reload),
    .load_now_i  (load_now),
    .load_data_i (wdata_i),
    .value_o     (value),
    .expire_o    (expire)
  );

  assign irq_o = raw & ctrl.ie;
endmodule

// File: rtl/interval_timer_checker.sv
module interval_timer_checker
  import timer_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input ctrl_t             ctrl,
  input logic [DATA_W-1:0] reload,
  input logic [DATA_W-1:0] value,
  input logic              raw,
  input logic              step,
  input logic              expire
);
  assert_irq_needs_ie_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctrl.ie);

  assert_clear_drops_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == IDX_ICLR && !expire) |=> !raw);

  assert_expiry_sets_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> raw);

  assert_oneshot_halt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.oneshot && value == '0 && !wr_i) |=> $stable(value) && !expire);

  assert_value_write_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == IDX_VALUE) |=> $stable(reload) && $stable(ctrl));

  assert_bgload_defers_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == IDX_BGLD && !step) |=> $stable(value));

  assert_no_step_disabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.en |-> !step);

  assert_narrow_upper_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.size32 && addr_i == IDX_VALUE) |-> rdata_o[DATA_W-1:NARROW_W] == '0);
endmodule

bind interval_timer interval_timer_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .ctrl    (ctrl),
  .reload  (reload),
  .value   (value),
  .raw     (raw),
  .step    (step),
  .expire  (expire)
);

// File: tb/interval_timer_test.sv
module interval_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  localparam logic [31:0] EN = 32'h80, PER = 32'h40, IE = 32'h20, W32 = 32'h02, ONE_SHOT = 32'h01;

  always #2 clk = ~clk;

  interval_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] idx, input logic [31:0] v);
    @(negedge clk); wr = 1'b1; addr = idx; wdata = v;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] idx, output logic [31:0] v);
    @(negedge clk); addr = idx; #1; v = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic expect_reg(input string tag, input logic [2:0] idx, input logic [31:0] exp);
    logic [31:0] v;
    rreg(idx, v);
    chk(tag, v, exp);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_reg("R1 ctrl", 3'd2, 32'h20);
    expect_reg("R1 value", 3'd1, 32'h0000FFFF);
    expect_reg("R1 load", 3'd0, 32'h0);
    expect_reg("R1 raw", 3'd4, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R3 control readback, upper bits zero
    wreg(3'd2, 32'hFFFF_FF5E);
    expect_reg("R3 ctrl readback", 3'd2, 32'h5E);

    // R2/R8 load reloads at once, periodic 32-bit, disabled
    wreg(3'd2, PER | W32 | IE);
    wreg(3'd0, 32'd10);
    expect_reg("R2 R8 load imm value", 3'd1, 32'd10);
    expect_reg("R8 load readback", 3'd0, 32'd10);
    ticks(5);
    expect_reg("R4 no step when disabled", 3'd1, 32'd10);

    // R5 periodic sweep over N
    for (int n = 1; n <= 6; n++) begin
      wreg(3'd2, EN | PER | IE | W32);
      wreg(3'd3, 32'd0);
      wreg(3'd0, 32'(n));
      if (n > 1) begin
        ticks(n - 1);
        expect_reg("R5 before expiry value", 3'd1, 32'd1);
        expect_reg("R5 before expiry raw", 3'd4, 32'd0);
      end
      ticks(1);
      expect_reg("R5 expiry raw", 3'd4, 32'd1);
      expect_reg("R5 reload value", 3'd1, 32'(n));
      chk("R10 irq with ie", {31'b0, irq}, 32'd1);
    end

    // R9 clear by any write data
    wreg(3'd3, 32'hDEAD_BEEF);
    expect_reg("R9 cleared", 3'd4, 32'd0);

    // R4 prescale codes, load 2: expiry after 2*div ticks
    for (int c = 0; c < 4; c++) begin
      int div;
      div = (c == 1) ? 16 : (c == 2) ? 256 : 1;
      wreg(3'd2, EN | PER | IE | W32 | 32'(c << 2));
      wreg(3'd0, 32'd2);
      wreg(3'd3, 32'd0);
      ticks(div);
      expect_reg("R4 one step value", 3'd1, 32'd1);
      ticks(div - 1);
      expect_reg("R4 pre-expiry raw", 3'd4, 32'd0);
      ticks(1);
      expect_reg("R4 expiry raw", 3'd4, 32'd1);
    end

    // R7 one-shot halt
    wreg(3'd2, EN | ONE_SHOT | IE | W32);
    wreg(3'd0, 32'd3);
    wreg(3'd3, 32'd0);
    ticks(3);
    expect_reg("R7 oneshot value zero", 3'd1, 32'd0);
    expect_reg("R7 oneshot raw", 3'd4, 32'd1);
    wreg(3'd3, 32'd0);
    ticks(20);
    expect_reg("R7 halted value", 3'd1, 32'd0);
    expect_reg("R7 no further flag", 3'd4, 32'd0);

    // R6 free-running wrap, reached via a small periodic count
    for (int w = 0; w < 2; w++) begin
      logic [31:0] sz;
      sz = w ? W32 : 32'd0;
      wreg(3'd2, PER | IE | sz);
      wreg(3'd0, 32'd3);
      wreg(3'd2, EN | IE | sz);
      wreg(3'd3, 32'd0);
      ticks(3);
      expect_reg("R6 free wrap flag", 3'd4, 32'd1);
      expect_reg("R6 free wrap value", 3'd1, w ? 32'hFFFF_FFFF : 32'h0000_FFFF);
      ticks(2);
      expect_reg("R6 free count down", 3'd1, w ? 32'hFFFF_FFFD : 32'h0000_FFFD);
    end
    wreg(3'd0, 32'd7);
    expect_reg("R8 free load gives max", 3'd1, 32'hFFFF_FFFF);

    // R8 background load deferred
    wreg(3'd2, EN | PER | IE | W32);
    wreg(3'd0, 32'd4);
    wreg(3'd3, 32'd0);
    ticks(1);
    wreg(3'd6, 32'd2);
    expect_reg("R8 bg keeps count", 3'd1, 32'd3);
    expect_reg("R8 bg readback", 3'd6, 32'd2);
    expect_reg("R8 bg readback idx0", 3'd0, 32'd2);
    ticks(3);
    expect_reg("R8 bg reload at wrap", 3'd1, 32'd2);

    // R10 mask
    wreg(3'd2, PER | W32);
    expect_reg("R10 raw unmasked", 3'd4, 32'd1);
    expect_reg("R10 masked zero", 3'd5, 32'd0);
    chk("R10 irq low", {31'b0, irq}, 32'd0);
    wreg(3'd2, PER | W32 | IE);
    expect_reg("R10 masked set", 3'd5, 32'd1);
    chk("R10 irq high", {31'b0, irq}, 32'd1);

    // R11 value write ignored
    rreg(3'd1, v);
    wreg(3'd1, 32'h1234_5678);
    expect_reg("R11 value kept", 3'd1, v);
    expect_reg("R11 load kept", 3'd0, 32'd2);
    expect_reg("R11 ctrl kept", 3'd2, PER | W32 | IE);

    // R12 16-bit view
    wreg(3'd2, PER | IE);
    wreg(3'd0, 32'h0001_2345);
    expect_reg("R12 narrow value", 3'd1, 32'h0000_2345);
    expect_reg("R12 load full", 3'd0, 32'h0001_2345);
    wreg(3'd2, EN | PER | IE);
    wreg(3'd3, 32'd0);
    ticks(32'h2345);
    expect_reg("R12 narrow reload", 3'd1, 32'h0000_2345);
    expect_reg("R12 narrow expiry", 3'd4, 32'd1);

    // R13 undefined indices
    wreg(3'd2, PER | IE | W32);
    wreg(3'd7, 32'hFFFF_FFFF);
    expect_reg("R13 idx3 zero", 3'd3, 32'd0);
    expect_reg("R13 idx7 zero", 3'd7, 32'd0);
    expect_reg("R13 ctrl kept", 3'd2, PER | IE | W32);
    expect_reg("R13 load kept", 3'd0, 32'h0001_2345);
    expect_reg("R13 raw kept", 3'd4, 32'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule